// File: doc/BRIEF.md
# Split-Access Debug Register Bridge

This block connects a host register-access path that is 16 bits wide to a bank of 32-bit debug registers inside a CPU core. Each core register is seen by the host as two 16-bit words, one low and one high. Host writes to these words land in a shadow copy held in the bridge. The core register is only changed when the host writes an update register that names a register pair. That write pushes the full value and control words of the pair to the core in one cycle, so the core never sees a half-written register.

Reads return the live core value, one half at a time. Reads are meant to happen while the core is halted, so the value cannot change between the two halves. The bridge does not match breakpoints itself. The core reports matches on a hit vector. On a fresh rising edge of that vector, the bridge stalls the core and sends a one-word event. The event holds the index of the lowest-numbered active hit. The stall stays asserted until the host writes a resume bit.

Top module: `dbg_split_bridge`

## Requirements
- R1: After reset, core_stall, evt_valid, core_wr_en and host_rvalid are all 0.
- R2: Host word address 4*i+f addresses pair i, where f=0 is the value low half, f=1 the value high half, f=2 the control low half and f=3 the control high half. A write to these words changes only the shadow copy and never raises core_wr_en.
- R3: A host write to address 4*NUM_PAIRS (32 by default) commits the pair whose index is in host_wdata[2:0]. One cycle later, core_wr_en is high for exactly one cycle. In that cycle core_wr_idx carries the index, core_wr_val carries {value high, value low} and core_wr_ctl carries {control high, control low}, all taken from the shadow copy.
- R4: The shadow copy keeps its contents after a commit. Rewriting one half and committing again changes only that half of the committed word.
- R5: A host read of address a below 4*NUM_PAIRS drives core_rd_idx = {a[4:2], a[1]}, where bit 0 selects value (0) or control (1), with no delay. On the next cycle host_rvalid is 1 and host_rdata is core_rd_data[15:0] for a[0]=0 or core_rd_data[31:16] for a[0]=1. A read of any other address returns 0.
- R6: When the bridge is not stalled, has no pending event, and some bit of core_hit goes from 0 to 1, core_stall and evt_valid both rise on the next cycle. evt_data then holds the index of the lowest set bit of core_hit, zero-extended.
- R7: evt_valid stays high and evt_data stays unchanged until a cycle in which evt_ready is high. evt_valid is low on the cycle after that handshake.
- R8: While core_stall is high, hit edges start no new event. A host write to address 4*NUM_PAIRS+1 with bit 0 set clears core_stall on the next cycle. The same write with bit 0 clear has no effect.
- R9: After a resume, hit bits that are already high do not start an event. Only a new 0-to-1 transition of some hit bit does.
- R10: Host writes to addresses above 4*NUM_PAIRS+1 raise no core write and leave core_stall unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| core_wr_en | output | 1 | Commit strobe to the core |
| core_wr_idx | output | 3 | Pair index being committed |
| core_wr_val | output | 32 | Committed value word |
| core_wr_ctl | output | 32 | Committed control word |
| core_rd_idx | output | 4 | Live read select: {pair, control} |
| core_rd_data | input | 32 | Core register selected by core_rd_idx |
| core_hit | input | 8 | Breakpoint hit vector from the core |
| core_stall | output | 1 | Stall request to the core |
| evt_valid | output | 1 | Event word valid |
| evt_ready | input | 1 | Event word accepted |
| evt_data | output | 16 | Event payload: breakpoint index |

## Verification
Every registered result is due exactly one clock after the edge that samples its cause. The commit strobe follows the update write by one cycle. Read data follows the read strobe by one cycle. Stall and event follow the first hit edge seen by the input register by one cycle. Stall release follows the resume write by one cycle. core_rd_idx is combinational and is checked in the same cycle as the address. The bench drives inputs on the falling edge and checks on the next falling edge, so each registered result is checked half a period after the single rising edge that produces it.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  // Field selector inside a four-word pair window (address bits [1:0]).
  localparam logic [1:0] FLD_VAL_LO = 2'd0;
  localparam logic [1:0] FLD_VAL_HI = 2'd1;
  localparam logic [1:0] FLD_CTL_LO = 2'd2;
  localparam logic [1:0] FLD_CTL_HI = 2'd3;

  // Index of the lowest set bit; scanned from the top so the last hit wins.
  function automatic int unsigned lowest_set_idx(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int b = 31; b >= 0; b--) begin
      if (v[b]) idx = b;
    end
    return idx;
  endfunction

  // Pick one half of a register word.
  function automatic logic [15:0] pick_half(input logic [31:0] w, input logic hi);
    return hi ? w[31:16] : w[15:0];
  endfunction

endpackage

// File: rtl/dsb_shadow_bank.sv
module dsb_shadow_bank #(
  parameter int NUM_PAIRS = 8,
  parameter int HALF_W    = 16,
  localparam int IDX_W    = $clog2(NUM_PAIRS),
  localparam int REG_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sh_wr,
  input  logic [IDX_W-1:0]  sh_pair,
  input  logic [1:0]        sh_fld,
  input  logic [HALF_W-1:0] sh_data,
  input  logic              commit,
  input  logic [IDX_W-1:0]  commit_idx,
  output logic              core_wr_en,
  output logic [IDX_W-1:0]  core_wr_idx,
  output logic [REG_W-1:0]  core_wr_val,
  output logic [REG_W-1:0]  core_wr_ctl
);
  import dsb_pkg::*;

  logic [REG_W-1:0] shadow_val [NUM_PAIRS];
  logic [REG_W-1:0] shadow_ctl [NUM_PAIRS];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    wire hit_pair = sh_wr && (sh_pair == IDX_W'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_val[p] <= '0;
        shadow_ctl[p] <= '0;
      end else if (hit_pair) begin
        case (sh_fld)
          FLD_VAL_LO: shadow_val[p][HALF_W-1:0]     <= sh_data;
          FLD_VAL_HI: shadow_val[p][REG_W-1:HALF_W] <= sh_data;
          FLD_CTL_LO: shadow_ctl[p][HALF_W-1:0]     <= sh_data;
          default:    shadow_ctl[p][REG_W-1:HALF_W] <= sh_data;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_wr_en  <= 1'b0;
      core_wr_idx <= '0;
      core_wr_val <= '0;
      core_wr_ctl <= '0;
    end else begin
      core_wr_en <= commit;
      if (commit) begin
        core_wr_idx <= commit_idx;
        core_wr_val <= shadow_val[commit_idx];
        core_wr_ctl <= shadow_ctl[commit_idx];
      end
    end
  end

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_en && !$past(commit) |-> 1'b0) else $error("stray commit"); // R3
  AST_COMMIT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> core_wr_en && core_wr_idx == $past(commit_idx)); // R3

endmodule

// File: rtl/dsb_read_port.sv
module dsb_read_port #(
  parameter int HALF_W = 16,
  localparam int REG_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              rd_in_map,
  input  logic              rd_hi,
  input  logic [REG_W-1:0]  core_rd_data,
  output logic [HALF_W-1:0] rdata,
  output logic              rvalid
);
  import dsb_pkg::*;

  logic [HALF_W-1:0] half_sel;
  always_comb half_sel = rd_in_map ? pick_half(32'(core_rd_data), rd_hi) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= half_sel;
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !rd_in_map |=> rdata == '0); // R5

endmodule

// File: rtl/dsb_event_gen.sv
module dsb_event_gen #(
  parameter int HIT_W  = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIT_W-1:0]  core_hit,
  input  logic              resume,
  output logic              core_stall,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [HALF_W-1:0] evt_data,
  output logic              evt_fire
);
  import dsb_pkg::*;

  logic [HIT_W-1:0] hit_q;
  logic [HIT_W-1:0] hit_rise;

  always_comb begin
    hit_rise = core_hit & ~hit_q;
    evt_fire = (|hit_rise) && !core_stall && !evt_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q      <= '0;
      core_stall <= 1'b0;
      evt_valid  <= 1'b0;
      evt_data   <= '0;
    end else begin
      hit_q <= core_hit;
      if (evt_fire) begin
        core_stall <= 1'b1;
        evt_valid  <= 1'b1;
        evt_data   <= HALF_W'(lowest_set_idx(32'(core_hit)));
      end else begin
        if (evt_valid && evt_ready) evt_valid <= 1'b0;
        if (resume) core_stall <= 1'b0;
      end
    end
  end

  AST_EVT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> core_stall); // R6
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_data)); // R7
  AST_EVT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_ready |=> !evt_valid); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall && !resume |=> core_stall); // R8
  AST_NO_FIRE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> !$rose(evt_valid)); // R8

endmodule

// File: rtl/dbg_split_bridge.sv
module dbg_split_bridge #(
  parameter int NUM_PAIRS = 8,
  parameter int HALF_W    = 16,
  parameter int ADDR_W    = 6,
  localparam int IDX_W    = $clog2(NUM_PAIRS),
  localparam int REG_W    = 2 * HALF_W,
  localparam int MAP_WORDS = 4 * NUM_PAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [HALF_W-1:0] host_wdata,
  output logic [HALF_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              core_wr_en,
  output logic [IDX_W-1:0]  core_wr_idx,
  output logic [REG_W-1:0]  core_wr_val,
  output logic [REG_W-1:0]  core_wr_ctl,
  output logic [IDX_W:0]    core_rd_idx,
  input  logic [REG_W-1:0]  core_rd_data,
  input  logic [NUM_PAIRS-1:0] core_hit,
  output logic              core_stall,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [HALF_W-1:0] evt_data
);

  localparam logic [ADDR_W-1:0] UPD_ADDR    = ADDR_W'(MAP_WORDS);
  localparam logic [ADDR_W-1:0] RESUME_ADDR = ADDR_W'(MAP_WORDS + 1);

  // Named decode events, visible to assertions.
  logic             addr_in_map;
  logic             half_wr;
  logic             upd_wr;
  logic             resume_wr;
  logic [IDX_W-1:0] addr_pair;
  logic             evt_fire;

  always_comb begin
    addr_in_map = host_addr < ADDR_W'(MAP_WORDS);
    addr_pair   = host_addr[2 +: IDX_W];
    half_wr     = host_wr && addr_in_map;
    upd_wr      = host_wr && (host_addr == UPD_ADDR);
    resume_wr   = host_wr && (host_addr == RESUME_ADDR) && host_wdata[0];
    core_rd_idx = {addr_pair, host_addr[1]};
  end

  dsb_shadow_bank #(.NUM_PAIRS(NUM_PAIRS), .HALF_W(HALF_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .sh_wr      (half_wr),
    .sh_pair    (addr_pair),
    .sh_fld     (host_addr[1:0]),
    .sh_data    (host_wdata),
    .commit     (upd_wr),
    .commit_idx (host_wdata[IDX_W-1:0]),
    .core_wr_en (core_wr_en),
    .core_wr_idx(core_wr_idx),
    .core_wr_val(core_wr_val),
    .core_wr_ctl(core_wr_ctl)
  );

  dsb_read_port #(.HALF_W(HALF_W)) u_read (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd          (host_rd),
    .rd_in_map   (addr_in_map),
    .rd_hi       (host_addr[0]),
    .core_rd_data(core_rd_data),
    .rdata       (host_rdata),
    .rvalid      (host_rvalid)
  );

  dsb_event_gen #(.HIT_W(NUM_PAIRS), .HALF_W(HALF_W)) u_event (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_hit  (core_hit),
    .resume    (resume_wr),
    .core_stall(core_stall),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_data  (evt_data),
    .evt_fire  (evt_fire)
  );

  AST_HALF_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    half_wr |=> !core_wr_en); // R2
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    resume_wr && !evt_fire |=> !core_stall); // R8
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr > RESUME_ADDR && !evt_fire |=> !core_wr_en && core_stall == $past(core_stall)); // R10

endmodule

// File: tb/dbg_split_bridge_bench.sv
module dbg_split_bridge_bench;
  localparam int NP = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [5:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rvalid, core_wr_en, core_stall, evt_valid;
  logic evt_ready = 0;
  logic [2:0] core_wr_idx;
  logic [31:0] core_wr_val, core_wr_ctl, core_rd_data;
  logic [3:0] core_rd_idx;
  logic [7:0] core_hit = '0;
  logic [15:0] evt_data;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] core_regs [16];
  logic [31:0] exp_val [NP];
  logic [31:0] exp_ctl [NP];

  always #4 clk = ~clk;

  dbg_split_bridge u_dbg_split_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .core_wr_en(core_wr_en), .core_wr_idx(core_wr_idx),
    .core_wr_val(core_wr_val), .core_wr_ctl(core_wr_ctl), .core_rd_idx(core_rd_idx),
    .core_rd_data(core_rd_data), .core_hit(core_hit), .core_stall(core_stall),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data));

  // Core model: register file written by the commit strobe.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) core_regs[k] <= '0;
    end else if (core_wr_en) begin
      core_regs[{core_wr_idx, 1'b0}] <= core_wr_val;
      core_regs[{core_wr_idx, 1'b1}] <= core_wr_ctl;
    end
  end
  assign core_rd_data = core_regs[core_rd_idx];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Write one host word; returns at the falling edge after the capturing edge.
  task automatic hwrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  function automatic logic [31:0] val_of(input int i);
    return 32'((i + 1) * 32'h0123_4567) ^ 32'hA5A5_0F0F;
  endfunction
  function automatic logic [31:0] ctl_of(input int i);
    return {16'h00C0 + 16'(i), 16'h3000 | 16'(i * 3)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!core_stall && !evt_valid && !core_wr_en && !host_rvalid, "R1", {core_stall, evt_valid, core_wr_en, host_rvalid}, 0);

    // R2: fill shadows, no commit strobe ever
    for (int i = 0; i < NP; i++) begin
      exp_val[i] = val_of(i); exp_ctl[i] = ctl_of(i);
      for (int f = 0; f < 4; f++) begin
        logic [31:0] w;
        w = (f < 2) ? exp_val[i] : exp_ctl[i];
        hwrite(6'(i * 4 + f), (f % 2 == 1) ? w[31:16] : w[15:0]);
        check(!core_wr_en, "R2", 32'(core_wr_en), 0);
      end
    end

    // R3: commit each pair in reverse order
    for (int i = NP - 1; i >= 0; i--) begin
      hwrite(6'd32, 16'(i));
      check(core_wr_en && core_wr_idx == 3'(i), "R3 idx", {core_wr_en, 28'd0, core_wr_idx}, {1'b1, 28'd0, 3'(i)});
      check(core_wr_val == exp_val[i], "R3 val", core_wr_val, exp_val[i]);
      check(core_wr_ctl == exp_ctl[i], "R3 ctl", core_wr_ctl, exp_ctl[i]);
      @(negedge clk);
      check(!core_wr_en, "R3 pulse", 32'(core_wr_en), 0);
    end

    // R4: rewrite only value-high of pair 2
    hwrite(6'd9, 16'hBEEF);
    exp_val[2] = {16'hBEEF, exp_val[2][15:0]};
    hwrite(6'd32, 16'd2);
    check(core_wr_val == exp_val[2] && core_wr_ctl == exp_ctl[2], "R4", core_wr_val, exp_val[2]);
    @(negedge clk);

    // R5: read every mapped word and a few unmapped ones
    for (int a = 0; a < 36; a++) begin
      logic [31:0] w;
      logic [15:0] e;
      @(negedge clk);
      host_rd = 1; host_addr = 6'(a);
      #1;
      if (a < 32) check(core_rd_idx == 4'(a / 2), "R5 idx", 32'(core_rd_idx), 32'(a / 2));
      w = (a % 4 < 2) ? exp_val[a / 4 % NP] : exp_ctl[a / 4 % NP];
      e = (a >= 32) ? 16'h0 : ((a % 2 == 1) ? w[31:16] : w[15:0]);
      @(negedge clk);
      host_rd = 0;
      check(host_rvalid && host_rdata == e, "R5 data", {15'd0, host_rvalid, host_rdata}, {16'd1, e});
    end

    // R10: unmapped writes
    hwrite(6'd34, 16'hFFFF);
    check(!core_wr_en && !core_stall, "R10", {core_wr_en, core_stall}, 0);
    hwrite(6'd63, 16'h0007);
    check(!core_wr_en && !core_stall, "R10", {core_wr_en, core_stall}, 0);

    // R6..R9: sweep all nonzero hit vectors
    for (int v = 1; v < 256; v++) begin
      logic [7:0] hv;
      int exp_idx;
      hv = 8'(v);
      exp_idx = $clog2(int'(hv & (~hv + 8'd1)));
      @(negedge clk); core_hit = hv;
      @(negedge clk);
      check(core_stall && evt_valid && evt_data == 16'(exp_idx), "R6", {core_stall, evt_valid, evt_data}, {2'b11, 16'(exp_idx)});
      @(negedge clk);
      check(evt_valid && evt_data == 16'(exp_idx), "R7 hold", {evt_valid, evt_data}, {1'b1, 16'(exp_idx)});
      evt_ready = 1;
      @(negedge clk); evt_ready = 0;
      check(!evt_valid, "R7 drop", 32'(evt_valid), 0);
      if (v % 16 == 0) begin
        // R8: new edges while stalled start nothing; resume bit clear does nothing
        core_hit = 8'h00;
        @(negedge clk); core_hit = 8'hFF;
        @(negedge clk);
        check(!evt_valid && core_stall, "R8 stalled", {evt_valid, core_stall}, 1);
        hwrite(6'd33, 16'h0000);
        check(core_stall, "R8 no-resume", 32'(core_stall), 1);
        core_hit = hv;
      end
      hwrite(6'd33, 16'h0001);
      check(!core_stall, "R8 resume", 32'(core_stall), 0);
      repeat (2) @(negedge clk);
      check(!evt_valid && !core_stall, "R9 held hit", {evt_valid, core_stall}, 0);
      core_hit = 8'h00;
    end
    @(negedge clk);
    finish_run();
  end
endmodule